// File: doc/BRIEF.md
# Clock Source and Standby Mode Controller

This block is a synchronous state machine that decides which of three clock sources drives the CPU and which standby mode the chip is in. The three sources are a fast internal oscillator, a main external crystal or clock input, and a slow subsystem crystal or clock input. The controller reads the reset, a supply-good flag, halt and stop requests, snooze triggers, snooze completion, wakeup events and software source-switch requests. It drives one enable per source, a CPU clock select and the current state code.

There are ten states, and their codes are visible on `state_code`:

| Code | State | Meaning |
|------|-------|---------|
| 0 | CM_RESET | held in reset |
| 1 | CM_RUN_INT | CPU runs on the internal oscillator |
| 2 | CM_RUN_MAIN | CPU runs on the main source |
| 3 | CM_RUN_SUB | CPU runs on the subsystem source |
| 4 | CM_HALT_INT | halt, entered from CM_RUN_INT |
| 5 | CM_HALT_MAIN | halt, entered from CM_RUN_MAIN |
| 6 | CM_HALT_SUB | halt, entered from CM_RUN_SUB |
| 7 | CM_STOP_INT | stop, entered from CM_RUN_INT |
| 8 | CM_STOP_MAIN | stop, entered from CM_RUN_MAIN |
| 9 | CM_SNOOZE | snooze, entered from CM_STOP_INT |

The transitions are: power-up (CM_RESET to CM_RUN_INT), switch (run to run), halt entry and halt wake (run to halt and back), stop entry and stop wake (run to stop and back), snooze entry (CM_STOP_INT to CM_SNOOZE), snooze wake (CM_SNOOZE to CM_RUN_INT), snooze end (CM_SNOOZE to CM_STOP_INT) and supply loss (any state to CM_RESET).

Each state gives each source one of three policies: forced on, forced off, or following its software enable bit. A switch request is checked against the target source's enable and ready inputs. A request that fails the check, or an illegal stop request, raises a one-cycle error pulse and leaves the state unchanged.

Top module: `clkmode_ctrl`

## Requirements
- R1: While `rst_n` is low the state is 0 (CM_RESET) and all enables are 0. A low `supply_ok` forces state 0 at the next clock edge from any state. From state 0 with `supply_ok` high, the next edge enters state 1 (CM_RUN_INT).
- R2: `sel_valid` is 1 only in states 1 to 6. `cpu_sel` then shows the active source: 0 for internal, 1 for main, 2 for subsystem. In all other states `cpu_sel` is 0.
- R3: In a run or halt state, the active source's enable is 1 and each other source's enable equals its `sw_en` bit. The bits of `sw_en` and `src_rdy` are ordered {subsystem, main, internal}, bits 2, 1 and 0.
- R4: In a run state, `sel_req` naming another source (code in `sel_src`) whose `sw_en` and `src_rdy` bits are both 1 moves to that source's run state at the next edge, with no error.
- R5: A switch request whose target has its `sw_en` or `src_rdy` bit low, or that uses code 3, leaves the state unchanged. It pulses `req_err` high for exactly the next cycle. A request naming the current source does nothing and raises no error.
- R6: In a run state, `halt_req` moves to the halt state of the current source. The enables follow R3. `wake_evt` in a halt state returns to the run state the halt was entered from.
- R7: In CM_RUN_INT or CM_RUN_MAIN, `stop_req` moves to CM_STOP_INT or CM_STOP_MAIN respectively. In a stop state the internal and main enables are 0 and the subsystem enable equals `sw_en[2]`. `stop_req` takes priority over `halt_req`, and `halt_req` takes priority over `sel_req`. `wake_evt` returns to the run state the stop was entered from.
- R8: `stop_req` in CM_RUN_SUB is rejected: the state stays 3 and `req_err` pulses for one cycle.
- R9: `snooze_trig` in CM_STOP_INT moves to CM_SNOOZE. There the internal enable is 1, the main enable is 0 and the subsystem enable equals `sw_en[2]`. `snooze_trig` in CM_STOP_MAIN is ignored.
- R10: In CM_SNOOZE, `wake_evt` moves to CM_RUN_INT. Otherwise `snooze_done` returns to CM_STOP_INT. `wake_evt` wins when both are high.
- R11: In halt, stop and snooze states, switch requests and halt and stop requests are ignored and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| supply_ok | input | 1 | supply at or above the minimum operating level |
| halt_req | input | 1 | halt request |
| stop_req | input | 1 | stop request |
| snooze_trig | input | 1 | snooze trigger while stopped |
| snooze_done | input | 1 | snooze finished without an interrupt |
| wake_evt | input | 1 | wakeup event |
| sel_req | input | 1 | source switch request |
| sel_src | input | 2 | requested source code |
| sw_en | input | 3 | software enable per source |
| src_rdy | input | 3 | ready flag per source |
| en_int | output | 1 | internal oscillator enable |
| en_main | output | 1 | main source enable |
| en_sub | output | 1 | subsystem source enable |
| cpu_sel | output | 2 | CPU clock source code |
| sel_valid | output | 1 | `cpu_sel` is meaningful |
| req_err | output | 1 | one-cycle rejected-request pulse |
| state_code | output | 4 | current state code |

## Verification
The assertions assume that every request input is stable around the rising clock edge and that `src_rdy` reflects the oscillator at the edge where a switch is judged. They also assume `rst_n` is the only asynchronous input; `supply_ok` is sampled like any other request. The stimulus changes every input on the falling edge and holds it for one full cycle, so each request is seen at exactly one decision edge. Requests whose order matters, such as a stop together with a halt, or a wake together with a snooze end, are applied in the same cycle to exercise the priorities.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int NUM_SRC = 3;
    localparam int SRC_W   = $clog2(NUM_SRC + 1);
    localparam int ST_W    = 4;

    typedef enum logic [ST_W-1:0] {
        CM_RESET     = 4'd0,
        CM_RUN_INT   = 4'd1,
        CM_RUN_MAIN  = 4'd2,
        CM_RUN_SUB   = 4'd3,
        CM_HALT_INT  = 4'd4,
        CM_HALT_MAIN = 4'd5,
        CM_HALT_SUB  = 4'd6,
        CM_STOP_INT  = 4'd7,
        CM_STOP_MAIN = 4'd8,
        CM_SNOOZE    = 4'd9
    } cm_state_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_INT  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_SUB  = 2'd2,
        SRC_NONE = 2'd3
    } cm_src_e;

    typedef enum logic [1:0] {
        POL_OFF = 2'd0,
        POL_ON  = 2'd1,
        POL_SW  = 2'd2
    } cm_pol_e;

    function automatic logic is_run(cm_state_e st);
        return (st == CM_RUN_INT) || (st == CM_RUN_MAIN) || (st == CM_RUN_SUB);
    endfunction

    function automatic logic is_active(cm_state_e st);
        return is_run(st) || (st == CM_HALT_INT) || (st == CM_HALT_MAIN) ||
               (st == CM_HALT_SUB);
    endfunction

    function automatic cm_src_e src_of(cm_state_e st);
        case (st)
            CM_RUN_INT,  CM_HALT_INT:  return SRC_INT;
            CM_RUN_MAIN, CM_HALT_MAIN: return SRC_MAIN;
            CM_RUN_SUB,  CM_HALT_SUB:  return SRC_SUB;
            default:                   return SRC_NONE;
        endcase
    endfunction

    function automatic cm_state_e run_of(cm_src_e s);
        case (s)
            SRC_MAIN: return CM_RUN_MAIN;
            SRC_SUB:  return CM_RUN_SUB;
            default:  return CM_RUN_INT;
        endcase
    endfunction

    function automatic cm_state_e halt_of(cm_state_e st);
        case (st)
            CM_RUN_MAIN: return CM_HALT_MAIN;
            CM_RUN_SUB:  return CM_HALT_SUB;
            default:     return CM_HALT_INT;
        endcase
    endfunction

    // Per-state policy for one source.
    function automatic cm_pol_e policy_of(cm_state_e st, cm_src_e s);
        if (st == CM_RESET)
            return POL_OFF;
        if (is_active(st))
            return (src_of(st) == s) ? POL_ON : POL_SW;
        if (st == CM_SNOOZE)
            return (s == SRC_INT) ? POL_ON : ((s == SRC_SUB) ? POL_SW : POL_OFF);
        return (s == SRC_SUB) ? POL_SW : POL_OFF;
    endfunction

endpackage

// File: rtl/clkmode_req_check.sv
module clkmode_req_check
    import clkmode_pkg::*;
(
    input  cm_src_e              cur_src,
    input  logic                 sel_req,
    input  logic [SRC_W-1:0]     sel_src,
    input  logic [NUM_SRC-1:0]   sw_en,
    input  logic [NUM_SRC-1:0]   src_rdy,
    output logic                 sw_take,
    output logic                 sw_reject,
    output cm_src_e              sw_tgt
);

    logic [NUM_SRC-1:0] usable;
    logic               code_ok;
    logic               hit;
    logic               same;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_use
            assign usable[g] = sw_en[g] & src_rdy[g] & (sel_src == SRC_W'(g));
        end
    endgenerate

    assign code_ok = (sel_src < SRC_W'(NUM_SRC));
    assign hit     = |usable;
    assign same    = (sel_src == cur_src);
    assign sw_tgt  = cm_src_e'(sel_src);

    always_comb begin
        sw_take   = 1'b0;
        sw_reject = 1'b0;
        if (sel_req && !same) begin
            if (code_ok && hit)
                sw_take = 1'b1;
            else
                sw_reject = 1'b1;
        end
    end

endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
    import clkmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      supply_ok,
    input  logic      halt_req,
    input  logic      stop_req,
    input  logic      snooze_trig,
    input  logic      snooze_done,
    input  logic      wake_evt,
    input  logic      sw_take,
    input  logic      sw_reject,
    input  cm_src_e   sw_tgt,
    output cm_state_e state,
    output logic      req_err
);

    cm_state_e nxt;
    logic      err_d;

    always_comb begin
        nxt   = state;
        err_d = 1'b0;
        if (!supply_ok) begin
            nxt = CM_RESET;
        end else begin
            unique case (state)
                CM_RESET: nxt = CM_RUN_INT;
                CM_RUN_INT, CM_RUN_MAIN, CM_RUN_SUB: begin
                    if (stop_req) begin
                        if (state == CM_RUN_SUB)
                            err_d = 1'b1;
                        else if (state == CM_RUN_INT)
                            nxt = CM_STOP_INT;
                        else
                            nxt = CM_STOP_MAIN;
                    end else if (halt_req) begin
                        nxt = halt_of(state);
                    end else if (sw_take) begin
                        nxt = run_of(sw_tgt);
                    end else if (sw_reject) begin
                        err_d = 1'b1;
                    end
                end
                CM_HALT_INT:  if (wake_evt) nxt = CM_RUN_INT;
                CM_HALT_MAIN: if (wake_evt) nxt = CM_RUN_MAIN;
                CM_HALT_SUB:  if (wake_evt) nxt = CM_RUN_SUB;
                CM_STOP_INT: begin
                    if (wake_evt)
                        nxt = CM_RUN_INT;
                    else if (snooze_trig)
                        nxt = CM_SNOOZE;
                end
                CM_STOP_MAIN: if (wake_evt) nxt = CM_RUN_MAIN;
                CM_SNOOZE: begin
                    if (wake_evt)
                        nxt = CM_RUN_INT;
                    else if (snooze_done)
                        nxt = CM_STOP_INT;
                end
                default: nxt = CM_RESET;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CM_RESET;
        else
            state <= nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            req_err <= 1'b0;
        else
            req_err <= err_d;
    end

    AST_SUPPLY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> state == CM_RESET); // R1

    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> state == $past(state)); // R5

    AST_SWITCH_CHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CM_RUN_MAIN && ($past(state) == CM_RUN_INT || $past(state) == CM_RUN_SUB))
        |-> $past(sw_take)); // R4

    AST_SUB_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CM_RUN_SUB) |=> !(state == CM_STOP_INT || state == CM_STOP_MAIN)); // R8

    AST_SNOOZE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CM_SNOOZE && $past(state) != CM_SNOOZE) |-> $past(state) == CM_STOP_INT); // R9

endmodule

// File: rtl/clkmode_osc_map.sv
module clkmode_osc_map
    import clkmode_pkg::*;
(
    input  cm_state_e            state,
    input  logic [NUM_SRC-1:0]   sw_en,
    output logic [NUM_SRC-1:0]   src_en,
    output cm_src_e              cpu_sel,
    output logic                 sel_valid
);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            cm_pol_e pol;
            assign pol       = policy_of(state, cm_src_e'(SRC_W'(g)));
            assign src_en[g] = (pol == POL_ON) | ((pol == POL_SW) & sw_en[g]);
        end
    endgenerate

    always_comb begin
        sel_valid = is_active(state);
        cpu_sel   = sel_valid ? src_of(state) : SRC_INT;
    end

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 supply_ok,
    input  logic                 halt_req,
    input  logic                 stop_req,
    input  logic                 snooze_trig,
    input  logic                 snooze_done,
    input  logic                 wake_evt,
    input  logic                 sel_req,
    input  logic [SRC_W-1:0]     sel_src,
    input  logic [NUM_SRC-1:0]   sw_en,
    input  logic [NUM_SRC-1:0]   src_rdy,
    output logic                 en_int,
    output logic                 en_main,
    output logic                 en_sub,
    output logic [SRC_W-1:0]     cpu_sel,
    output logic                 sel_valid,
    output logic                 req_err,
    output logic [ST_W-1:0]      state_code
);

    cm_state_e          state;
    cm_src_e            sw_tgt;
    cm_src_e            sel_src_e;
    logic               sw_take;
    logic               sw_reject;
    logic [NUM_SRC-1:0] src_en;

    clkmode_req_check u_check (
        .cur_src   (src_of(state)),
        .sel_req   (sel_req),
        .sel_src   (sel_src),
        .sw_en     (sw_en),
        .src_rdy   (src_rdy),
        .sw_take   (sw_take),
        .sw_reject (sw_reject),
        .sw_tgt    (sw_tgt)
    );

    clkmode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .halt_req    (halt_req),
        .stop_req    (stop_req),
        .snooze_trig (snooze_trig),
        .snooze_done (snooze_done),
        .wake_evt    (wake_evt),
        .sw_take     (sw_take),
        .sw_reject   (sw_reject),
        .sw_tgt      (sw_tgt),
        .state       (state),
        .req_err     (req_err)
    );

    clkmode_osc_map u_map (
        .state     (state),
        .sw_en     (sw_en),
        .src_en    (src_en),
        .cpu_sel   (sel_src_e),
        .sel_valid (sel_valid)
    );

    assign en_int     = src_en[SRC_INT];
    assign en_main    = src_en[SRC_MAIN];
    assign en_sub     = src_en[SRC_SUB];
    assign cpu_sel    = sel_src_e;
    assign state_code = state;

    AST_SEL_SOURCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && cpu_sel == SRC_MAIN) |-> en_main); // R2

    AST_STOP_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CM_STOP_INT || state == CM_STOP_MAIN) |-> (!en_int && !en_main)); // R7

    AST_SNOOZE_INT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CM_SNOOZE) |-> (en_int && !en_main && !sel_valid)); // R9

endmodule

// File: tb/clkmode_ctrl_bench.sv
`timescale 1ns/1ps
module clkmode_ctrl_bench;

    typedef struct packed {
        logic       sup;
        logic       hlt;
        logic       stp;
        logic       snz;
        logic       wak;
        logic       dne;
        logic       sel;
        logic [1:0] src;
        logic [2:0] swen;
        logic [2:0] rdy;
        logic [3:0] x_st;
        logic [2:0] x_en;
        logic [1:0] x_sel;
        logic       x_err;
    } vec_t;

    localparam int NV = 32;
    // sup hlt stp snz wak dne sel src swen rdy | state en{sub,main,int} sel err
    localparam vec_t VEC [NV] = '{
        '{1,0,0,0,0,0,0,0,3'b000,3'b111, 1,3'b001,0,0}, // 0  R1 power-up
        '{1,0,0,0,0,0,1,1,3'b010,3'b101, 1,3'b011,0,1}, // 1  R5 not ready
        '{1,0,0,0,0,0,1,1,3'b000,3'b111, 1,3'b001,0,1}, // 2  R5 not enabled
        '{1,0,0,0,0,0,1,1,3'b010,3'b111, 2,3'b010,1,0}, // 3  R4 to main
        '{1,1,0,0,0,0,0,0,3'b000,3'b111, 5,3'b010,1,0}, // 4  R6 halt
        '{1,0,0,0,0,0,0,0,3'b000,3'b111, 5,3'b010,1,0}, // 5  R6 hold
        '{1,0,0,0,0,0,1,2,3'b100,3'b111, 5,3'b110,1,0}, // 6  R11 ignored
        '{1,0,0,0,1,0,0,0,3'b000,3'b111, 2,3'b010,1,0}, // 7  R6 wake
        '{1,0,1,0,0,0,0,0,3'b000,3'b111, 8,3'b000,0,0}, // 8  R7 stop main
        '{1,0,0,1,0,0,0,0,3'b000,3'b111, 8,3'b000,0,0}, // 9  R9 snooze ignored
        '{1,0,0,0,1,0,0,0,3'b000,3'b111, 2,3'b010,1,0}, // 10 R7 wake
        '{1,0,0,0,0,0,1,2,3'b100,3'b111, 3,3'b100,2,0}, // 11 R4 to sub
        '{1,0,1,0,0,0,0,0,3'b100,3'b111, 3,3'b100,2,1}, // 12 R8
        '{1,1,0,0,0,0,0,0,3'b100,3'b111, 6,3'b100,2,0}, // 13 R6 halt sub
        '{1,0,0,0,1,0,0,0,3'b100,3'b111, 3,3'b100,2,0}, // 14 R6 wake
        '{1,0,0,0,0,0,1,0,3'b100,3'b111, 3,3'b100,2,1}, // 15 R5
        '{1,0,0,0,0,0,1,0,3'b101,3'b110, 3,3'b101,2,1}, // 16 R5
        '{1,0,0,0,0,0,1,0,3'b101,3'b111, 1,3'b101,0,0}, // 17 R4 to int
        '{1,0,0,0,0,0,1,3,3'b101,3'b111, 1,3'b101,0,1}, // 18 R5 code 3
        '{1,0,1,0,0,0,0,0,3'b100,3'b111, 7,3'b100,0,0}, // 19 R7 stop int
        '{1,0,0,1,0,0,0,0,3'b100,3'b111, 9,3'b101,0,0}, // 20 R9 snooze
        '{1,0,0,0,0,1,0,0,3'b100,3'b111, 7,3'b100,0,0}, // 21 R10 back
        '{1,0,0,1,0,0,0,0,3'b000,3'b111, 9,3'b001,0,0}, // 22 R9
        '{1,0,0,0,1,1,0,0,3'b000,3'b111, 1,3'b001,0,0}, // 23 R10 wake wins
        '{1,1,1,0,0,0,0,0,3'b010,3'b111, 7,3'b000,0,0}, // 24 R7 priority
        '{1,0,0,0,1,0,0,0,3'b000,3'b111, 1,3'b001,0,0}, // 25 R7 wake
        '{0,0,0,0,0,0,0,0,3'b000,3'b111, 0,3'b000,0,0}, // 26 R1 supply low
        '{0,1,0,0,0,0,0,0,3'b000,3'b111, 0,3'b000,0,0}, // 27 R1 hold
        '{1,0,0,0,0,0,0,0,3'b000,3'b111, 1,3'b001,0,0}, // 28 R1 restart
        '{1,0,0,0,0,0,1,0,3'b000,3'b111, 1,3'b001,0,0}, // 29 R5 same src
        '{1,1,0,0,0,0,0,0,3'b110,3'b111, 4,3'b111,0,0}, // 30 R3 halt int
        '{1,0,0,0,1,0,0,0,3'b110,3'b111, 1,3'b111,0,0}  // 31 R3 run int
    };

    function automatic string tag_of(int i);
        case (i)
            0, 26, 27, 28:          return "R1";
            30, 31:                 return "R3";
            3, 11, 17:              return "R4";
            1, 2, 15, 16, 18, 29:   return "R5";
            4, 5, 7, 13, 14:        return "R6";
            8, 10, 19, 24, 25:      return "R7";
            12:                     return "R8";
            9, 20, 22:              return "R9";
            21, 23:                 return "R10";
            6:                      return "R11";
            default:                return "R2";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok, halt_req, stop_req, snooze_trig, snooze_done, wake_evt, sel_req;
    logic [1:0] sel_src;
    logic [2:0] sw_en, src_rdy;
    logic       en_int, en_main, en_sub, sel_valid, req_err;
    logic [1:0] cpu_sel;
    logic [3:0] state_code;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    clkmode_ctrl u_clkmode_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .halt_req(halt_req),
        .stop_req(stop_req), .snooze_trig(snooze_trig), .snooze_done(snooze_done),
        .wake_evt(wake_evt), .sel_req(sel_req), .sel_src(sel_src), .sw_en(sw_en),
        .src_rdy(src_rdy), .en_int(en_int), .en_main(en_main), .en_sub(en_sub),
        .cpu_sel(cpu_sel), .sel_valid(sel_valid), .req_err(req_err),
        .state_code(state_code)
    );

    task automatic check(input string tag, input logic [3:0] st, input logic [2:0] en,
                         input logic [1:0] sel, input logic err);
        logic [11:0] act, exp;
        logic        vld;
        vld = (st >= 4'd1) && (st <= 4'd6);
        act = {state_code, en_sub, en_main, en_int, cpu_sel, sel_valid, req_err};
        exp = {st, en, sel, vld, err};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act st=%0d en=%b sel=%0d vld=%b err=%b exp st=%0d en=%b sel=%0d vld=%b err=%b",
                     tag, state_code, {en_sub, en_main, en_int}, cpu_sel, sel_valid, req_err,
                     st, en, sel, vld, err);
        end
    endtask

    task automatic apply(input vec_t v);
        supply_ok   = v.sup;
        halt_req    = v.hlt;
        stop_req    = v.stp;
        snooze_trig = v.snz;
        wake_evt    = v.wak;
        snooze_done = v.dne;
        sel_req     = v.sel;
        sel_src     = v.src;
        sw_en       = v.swen;
        src_rdy     = v.rdy;
    endtask

    initial begin
        rst_n = 1'b0;
        apply('{1,0,0,0,0,0,0,0,3'b000,3'b111, 0,3'b000,0,0});
        repeat (3) @(negedge clk);
        check("R1", 4'd0, 3'b000, 2'd0, 1'b0);    // reset state
        check("R2", 4'd0, 3'b000, 2'd0, 1'b0);    // no valid select in reset
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check(tag_of(i), VEC[i].x_st, VEC[i].x_en, VEC[i].x_sel, VEC[i].x_err);
        end
        // R2: main source selected and shown
        apply('{1,0,0,0,0,0,1,1,3'b010,3'b111, 0,3'b000,0,0});
        @(negedge clk);
        check("R2", 4'd2, 3'b010, 2'd1, 1'b0);
        // R1: asynchronous reset mid-run
        apply('{1,0,0,0,0,0,0,0,3'b000,3'b111, 0,3'b000,0,0});
        #5 rst_n = 1'b0;
        #1 check("R1", 4'd0, 3'b000, 2'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 4'd1, 3'b001, 2'd0, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule